// File: doc/BRIEF.md
# Command Packet Queue

This block queues command-mode packets written by a register interface and serialises them as a byte stream for a serial display link. Software first pushes any payload as 32-bit words through the payload register. It then writes the header register, which holds an 8-bit data type and a 16-bit field. Writing the header is what starts a packet. For a short packet the 16-bit field carries up to two parameter bytes. For a long packet it is the number of payload bytes.

The output is a byte stream with a valid/ready handshake. Each packet begins with three header bytes: the type, then the low and high bytes of the 16-bit field. A long packet follows these with its payload bytes, taken little-endian from each queued word. A long header stays queued until the payload FIFO holds enough words to cover its byte count. Pad bytes in the final word are dropped. A status byte reports the fill state of both FIFOs and a sticky overflow flag.

Top module: `cmd_pkt_queue`

## Requirements
- R1: After reset, status reads 0x15 and out_valid is low.
- R2: Status bit 0 is command FIFO empty and bit 1 is command FIFO full. Bit 2 is payload FIFO empty and bit 3 is payload FIFO full. Bit 4 reads 1 and bits 5 and 6 read 0, since there is no read path. Empty and full of one FIFO are never set together.
- R3: A header write (wr_sel=0) takes the type from wr_data[7:0] and the 16-bit field from wr_data[23:8]. The packet then emits three bytes: type, field[7:0], field[15:8]. out_last is set on the third byte when the packet has no payload.
- R4: A type whose low nibble is 0x9, 0xC, 0xD or 0xE is long. After its three header bytes it emits exactly field bytes, taken from payload words (wr_sel=1) byte 0 first. out_last is set only on the final byte.
- R5: The unused upper bytes of a long packet's last word are discarded together with that word. The next packet's payload starts at the following word.
- R6: A long header produces no output until ceil(field/4) payload words are queued.
- R7: A write to a full FIFO is dropped without changing that FIFO's contents. It sets status bit 7, which stays set until reset.
- R8: While out_valid is high and out_ready is low, out_byte and out_last hold their values. The stream advances only on valid and ready together.
- R9: After a long packet whose payload exactly matched its count, status bits 0 and 2 are both set.
- R10: Packets leave in the order their headers were written.
- R11: A long packet with a zero field emits only its three header bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the header register, 1 selects the payload register |
| wr_data | input | 32 | Register write data |
| status | output | 8 | FIFO flags and sticky overflow |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Sink accepts the byte |
| out_byte | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the packet |

## Verification
The bench builds the block with a command FIFO depth of 4 and a payload depth of 8 words. At these depths both full flags and both overflow paths can be reached with a handful of writes. Holding the sink stalled lets four headers queue behind the one in flight, so a fifth queued write overflows. Eight payload words fill the payload FIFO and can then be drained as a single 32-byte packet. That drain shows the dropped ninth word never entered the FIFO.

// File: rtl/cmd_pkt_pkg.sv
package cmd_pkt_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned TYPE_W  = 8;
  localparam int unsigned FIELD_W = 16;
  localparam int unsigned HDR_W   = TYPE_W + FIELD_W;

  // status bit positions
  localparam int unsigned ST_CMD_EMPTY = 0;
  localparam int unsigned ST_CMD_FULL  = 1;
  localparam int unsigned ST_PLD_EMPTY = 2;
  localparam int unsigned ST_PLD_FULL  = 3;
  localparam int unsigned ST_RD_EMPTY  = 4;
  localparam int unsigned ST_RD_FULL   = 5;
  localparam int unsigned ST_RD_BUSY   = 6;
  localparam int unsigned ST_OVF       = 7;

  typedef struct packed {
    logic [FIELD_W-1:0] field;
    logic [TYPE_W-1:0]  dtype;
  } cmd_hdr_t;

  typedef enum logic [2:0] {
    SER_IDLE, SER_TYPE, SER_LO, SER_HI, SER_PLD
  } ser_state_e;

  // long-packet classification by type low nibble
  function automatic logic is_long_type(input logic [TYPE_W-1:0] dt);
    case (dt[3:0])
      4'h9, 4'hC, 4'hD, 4'hE: return 1'b1;
      default:                return 1'b0;
    endcase
  endfunction

  // payload words needed to hold n bytes (ceiling of n/4)
  function automatic logic [FIELD_W:0] words_for_bytes(input logic [FIELD_W-1:0] n);
    logic [FIELD_W+1:0] s;
    s = {2'b00, n} + (FIELD_W+2)'(3);
    return s[FIELD_W+1:2];
  endfunction
endpackage

// File: rtl/cpq_fifo.sv
module cpq_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [WIDTH-1:0]             push_data,
  input  logic                         pop,
  output logic [WIDTH-1:0]             head,
  output logic                         empty,
  output logic                         full,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH+1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;
  logic             do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign count   = cnt;
  assign head    = mem[rp];
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= ptr_next(wp);
      if (do_pop)  rp <= ptr_next(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/cpq_serializer.sv
module cpq_serializer
  import cmd_pkt_pkg::*;
#(
  parameter int unsigned PLD_CW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_empty,
  input  cmd_hdr_t             cmd_head,
  output logic                 cmd_pop,
  input  logic [WORD_W-1:0]    pld_head,
  input  logic [PLD_CW-1:0]    pld_count,
  output logic                 pld_pop,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [7:0]           out_byte,
  output logic                 out_last,
  output logic                 hdr_launch
);
  ser_state_e           state;
  cmd_hdr_t             hdr_q;
  logic                 long_q;
  logic [FIELD_W-1:0]   remain;
  logic [1:0]           lane;
  logic                 fire, has_pld, enough;

  assign enough     = (32'(pld_count) >= 32'(words_for_bytes(cmd_head.field)));
  assign hdr_launch = (state == SER_IDLE) && !cmd_empty &&
                      (!is_long_type(cmd_head.dtype) || enough);
  assign cmd_pop    = hdr_launch;
  assign out_valid  = (state != SER_IDLE);
  assign fire       = out_valid && out_ready;
  assign has_pld    = long_q && (hdr_q.field != '0);
  assign pld_pop    = (state == SER_PLD) && fire &&
                      ((remain == FIELD_W'(1)) || (lane == 2'd3));

  always_comb begin
    case (state)
      SER_TYPE: out_byte = hdr_q.dtype;
      SER_LO:   out_byte = hdr_q.field[7:0];
      SER_HI:   out_byte = hdr_q.field[15:8];
      SER_PLD:  out_byte = pld_head[{lane, 3'b000} +: 8];
      default:  out_byte = 8'h00;
    endcase
  end

  assign out_last = ((state == SER_HI) && !has_pld) ||
                    ((state == SER_PLD) && (remain == FIELD_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SER_IDLE;
      hdr_q  <= '0;
      long_q <= 1'b0;
      remain <= '0;
      lane   <= '0;
    end else begin
      case (state)
        SER_IDLE: if (hdr_launch) begin
          hdr_q  <= cmd_head;
          long_q <= is_long_type(cmd_head.dtype);
          state  <= SER_TYPE;
        end
        SER_TYPE: if (fire) state <= SER_LO;
        SER_LO:   if (fire) state <= SER_HI;
        SER_HI:   if (fire) begin
          if (has_pld) begin
            state  <= SER_PLD;
            remain <= hdr_q.field;
            lane   <= '0;
          end else begin
            state <= SER_IDLE;
          end
        end
        SER_PLD:  if (fire) begin
          remain <= remain - FIELD_W'(1);
          lane   <= lane + 2'd1;
          if (remain == FIELD_W'(1)) state <= SER_IDLE;
        end
        default:  state <= SER_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cmd_pkt_queue.sv
module cmd_pkt_queue
  import cmd_pkt_pkg::*;
#(
  parameter int unsigned CMD_DEPTH = 4,
  parameter int unsigned PLD_DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [31:0] wr_data,
  output logic [7:0]  status,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_byte,
  output logic        out_last
);
  localparam int unsigned CMD_CW = $clog2(CMD_DEPTH+1);
  localparam int unsigned PLD_CW = $clog2(PLD_DEPTH+1);

  logic               hdr_wr, pld_wr;
  logic               cmd_empty, cmd_full, cmd_pop;
  logic               pld_empty, pld_full, pld_pop;
  logic [HDR_W-1:0]   cmd_head_raw;
  logic [WORD_W-1:0]  pld_head;
  logic [PLD_CW-1:0]  pld_count;
  logic [CMD_CW-1:0]  cmd_cnt_unused;
  logic               hdr_launch;
  logic               ovf_q;
  logic               wr_hi_unused;

  assign hdr_wr       = wr_en && !wr_sel;
  assign pld_wr       = wr_en &&  wr_sel;
  assign wr_hi_unused = ^wr_data[31:24];

  cpq_fifo #(.WIDTH(HDR_W), .DEPTH(CMD_DEPTH)) u_cmd_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(hdr_wr), .push_data(wr_data[HDR_W-1:0]),
    .pop(cmd_pop), .head(cmd_head_raw),
    .empty(cmd_empty), .full(cmd_full), .count(cmd_cnt_unused)
  );

  cpq_fifo #(.WIDTH(WORD_W), .DEPTH(PLD_DEPTH)) u_pld_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(pld_wr), .push_data(wr_data),
    .pop(pld_pop), .head(pld_head),
    .empty(pld_empty), .full(pld_full), .count(pld_count)
  );

  cpq_serializer #(.PLD_CW(PLD_CW)) u_ser (
    .clk(clk), .rst_n(rst_n),
    .cmd_empty(cmd_empty), .cmd_head(cmd_hdr_t'(cmd_head_raw)), .cmd_pop(cmd_pop),
    .pld_head(pld_head), .pld_count(pld_count), .pld_pop(pld_pop),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_byte(out_byte), .out_last(out_last),
    .hdr_launch(hdr_launch)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else if ((hdr_wr && cmd_full) || (pld_wr && pld_full)) ovf_q <= 1'b1;
  end

  always_comb begin
    status               = '0;
    status[ST_CMD_EMPTY] = cmd_empty;
    status[ST_CMD_FULL]  = cmd_full;
    status[ST_PLD_EMPTY] = pld_empty;
    status[ST_PLD_FULL]  = pld_full;
    status[ST_RD_EMPTY]  = 1'b1;
    status[ST_RD_FULL]   = 1'b0;
    status[ST_RD_BUSY]   = 1'b0;
    status[ST_OVF]       = ovf_q;
  end
endmodule

// File: rtl/cpq_chk.sv
module cpq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       wr_sel,
  input logic [7:0] status,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_byte,
  input logic       out_last,
  input logic       hdr_launch,
  input logic       pld_pop
);
  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_byte) && $stable(out_last));

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[7] |=> status[7]);

  // R7
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && status[1]) || (wr_en && wr_sel && status[3]) |=> status[7]);

  // R2
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[0] && status[1]) && !(status[2] && status[3]));

  // R10
  launch_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_launch |-> !status[0] && !out_valid);

  // R3
  launch_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_launch |=> out_valid);

  // R5
  pop_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pld_pop |-> !status[2] && out_valid && out_ready);
endmodule

bind cmd_pkt_queue cpq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
  .status(status), .out_valid(out_valid), .out_ready(out_ready),
  .out_byte(out_byte), .out_last(out_last),
  .hdr_launch(hdr_launch), .pld_pop(pld_pop)
);

// File: tb/cmd_pkt_queue_tb_top.sv
module cmd_pkt_queue_tb_top;
  localparam int CMD_D = 4;
  localparam int PLD_D = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [7:0]  status;
  logic        out_valid, out_last;
  logic        out_ready = 1'b0;
  logic [7:0]  out_byte;

  int   n_chk = 0;
  int   n_fail = 0;
  logic [7:0] exp_q[$];

  always #10 clk = ~clk;

  cmd_pkt_queue #(.CMD_DEPTH(CMD_D), .PLD_DEPTH(PLD_D)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .status(status), .out_valid(out_valid), .out_ready(out_ready),
    .out_byte(out_byte), .out_last(out_last)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic expect_hdr(input logic [7:0] t, input logic [15:0] f);
    exp_q.push_back(t); exp_q.push_back(f[7:0]); exp_q.push_back(f[15:8]);
  endtask

  task automatic expect_word(input logic [31:0] w, input int nb);
    for (int i = 0; i < nb; i++) exp_q.push_back(w[8*i +: 8]);
  endtask

  // stalled: ready drops one cycle in three
  task automatic collect(input string req, input bit stalled);
    int  idx = 0;
    int  waitc = 0;
    bit  seen_last = 0;
    while (!seen_last && waitc < 3000) begin
      @(negedge clk);
      waitc++;
      out_ready = stalled ? ((waitc % 3) != 0) : 1'b1;
      if (out_valid && out_ready) begin
        if (idx < exp_q.size()) check({req, " byte"}, {24'h0, out_byte}, {24'h0, exp_q[idx]});
        else check({req, " extra byte"}, 1, 0);
        check({req, " last"}, {31'h0, out_last}, {31'h0, (idx == exp_q.size() - 1)});
        idx++;
        seen_last = out_last;
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
    check({req, " byte count"}, idx, exp_q.size());
    exp_q.delete();
  endtask

  task automatic t_reset;
    check("R1 status", {24'h0, status}, 32'h15);
    check("R1 valid", {31'h0, out_valid}, 0);
  endtask

  task automatic t_short;
    wr(1'b0, 32'h00BEEF15);
    expect_hdr(8'h15, 16'hBEEF);
    collect("R3 short", 1'b0);
    check("R2 idle status", {24'h0, status}, 32'h15);
  endtask

  task automatic t_long;
    wr(1'b1, 32'h44332211);
    wr(1'b1, 32'h88776655);
    wr(1'b1, 32'h000000AA);
    check("R2 payload queued", {24'h0, status}, 32'h11);
    wr(1'b0, 32'h00000939);
    expect_hdr(8'h39, 16'd9);
    expect_word(32'h44332211, 4);
    expect_word(32'h88776655, 4);
    expect_word(32'h000000AA, 1);
    collect("R4 R8 long stalled", 1'b1);
    check("R9 empty after", {24'h0, status}, 32'h15);
  endtask

  task automatic t_pad;
    wr(1'b1, 32'h04030201);
    wr(1'b1, 32'hDDCCBB05);
    wr(1'b0, 32'h00000529);
    expect_hdr(8'h29, 16'd5);
    expect_word(32'h04030201, 4);
    expect_word(32'hDDCCBB05, 1);
    collect("R5 pad", 1'b0);
    check("R5 pad word gone", {31'h0, status[2]}, 1);
    wr(1'b1, 32'hA0B0C0D0);
    wr(1'b0, 32'h0000043E);
    expect_hdr(8'h3E, 16'd4);
    expect_word(32'hA0B0C0D0, 4);
    collect("R5 next word", 1'b0);
  endtask

  task automatic t_hold;
    wr(1'b1, 32'h11111111);
    wr(1'b1, 32'h22222222);
    wr(1'b0, 32'h00000C39);
    repeat (20) @(negedge clk);
    check("R6 held", {31'h0, out_valid}, 0);
    wr(1'b1, 32'h33333333);
    expect_hdr(8'h39, 16'd12);
    expect_word(32'h11111111, 4);
    expect_word(32'h22222222, 4);
    expect_word(32'h33333333, 4);
    collect("R6 released", 1'b0);
    check("R9 hold empty", {24'h0, status}, 32'h15);
  endtask

  task automatic t_zero;
    wr(1'b0, 32'h0000000E);
    expect_hdr(8'h0E, 16'd0);
    collect("R11 zero long", 1'b0);
  endtask

  task automatic t_order;
    wr(1'b0, 32'h00000105);
    wr(1'b0, 32'h00020015);
    wr(1'b0, 32'h00000323);
    expect_hdr(8'h05, 16'h0001);
    collect("R10 first", 1'b0);
    expect_hdr(8'h15, 16'h0200);
    collect("R10 second", 1'b0);
    expect_hdr(8'h23, 16'h0003);
    collect("R10 third", 1'b0);
  endtask

  task automatic t_overflow;
    for (int i = 0; i < 5; i++) wr(1'b0, 32'h00001005 + (i << 8));
    check("R2 cmd full", {31'h0, status[1]}, 1);
    check("R7 no ovf yet", {31'h0, status[7]}, 0);
    wr(1'b0, 32'h00007705);
    check("R7 cmd ovf", {31'h0, status[7]}, 1);
    for (int i = 0; i < 5; i++) begin
      expect_hdr(8'h05, 16'h0010 + 16'(i));
      collect("R7 kept headers", 1'b0);
    end
    check("R7 dropped header", {24'h0, status}, 32'h95);
    for (int i = 0; i < PLD_D; i++) wr(1'b1, 32'h01010101 * (i + 1));
    check("R2 pld full", {31'h0, status[3]}, 1);
    wr(1'b1, 32'hDEADBEEF);
    wr(1'b0, 32'h00002039);
    expect_hdr(8'h39, 16'd32);
    for (int i = 0; i < PLD_D; i++) expect_word(32'h01010101 * (i + 1), 4);
    collect("R7 pld kept", 1'b0);
    check("R7 sticky", {24'h0, status}, 32'h95);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_short();
    t_long();
    t_pad();
    t_hold();
    t_zero();
    t_order();
    t_overflow();
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule